// File: doc/BRIEF.md
# Chainable Loadable Binary Up-Counter

This block is a synchronous binary up-counter built from identical 4-bit slices. Each slice has an asynchronous active-low clear, a synchronous active-low parallel load and two count enables. One enable is a plain count permit. The other is a carry-enable, and it also qualifies the slice's terminal-count carry.

The top chains a parameter number of slices on one clock. Each slice's carry drives the carry-enable of the slice above it, and the load, clear and count permit go to every slice. The chain therefore behaves as one wide counter. Its carry output is high when the whole value is all ones and the carry-enable of the lowest slice is high. That carry can feed the carry-enable of a further chain.

Priority is fixed: clear first, then load, then increment, then hold.

Top module: `cnt_chain`

## Requirements
- R1: While `clrN` is low, `countOut` is 0 and `carryOut` is 0 at once, without waiting for a clock edge, and a rising edge does not change this.
- R2: When `loadN` is low at a rising edge of `clk` (and `clrN` is high), `countOut` takes `presetVal` after that edge, even if both enables are high; the load takes the place of the increment.
- R3: A load happens even when `countEn` and `carryEn` are both low.
- R4: When `loadN`, `countEn` and `carryEn` are all high at a rising edge, `countOut` increases by exactly one.
- R5: With `loadN` high and `countEn` low, `countOut` holds its value over the edge.
- R6: With `loadN` high and `carryEn` low, `countOut` holds its value over the edge.
- R7: `carryOut` is high exactly when `carryEn` is high and `countOut` is all ones; it is a combinational function of those two.
- R8: With `carryEn` low, `carryOut` is low even when `countOut` is all ones.
- R9: An increment from all ones wraps `countOut` to 0.
- R10: Slices are chained so that a lower slice at 1111 with carry lets the next slice count on the same edge; for example, 0x0F goes to 0x10 in one clock.
- R11: Bit 0 of `presetVal` and of `countOut` is the least significant bit, and each preset bit lands in the same bit position of the count (0x01 loads as 0x01, 0x80 as 0x80).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clrN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| countEn | input | 1 | Count permit to every slice |
| carryEn | input | 1 | Carry-enable of the lowest slice; also gates `carryOut` |
| presetVal | input | NUM_SLICES*SLICE_W | Value loaded on a load edge |
| countOut | output | NUM_SLICES*SLICE_W | Current count |
| carryOut | output | 1 | Terminal-count carry of the top slice |

## Verification
Load and increment can be asked for on the same edge. The bench provokes this by driving `loadN` low with both enables high, and judges the cycle correct only if the preset appears in place of count+1.

Clear and load can also meet on one edge. `clrN` is held low across an edge on which `loadN` is low, and the count must read 0 after that edge. A clear is also dropped partway through a clock period while the count sits at all ones, and both outputs are checked before the next edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Strobes from a slice's control to its datapath
  typedef struct packed {
    logic load;
    logic incr;
  } cntStrobe_t;
endpackage

// File: rtl/cnt_slice_ctrl.sv
module cnt_slice_ctrl
  import cnt_pkg::*;
(
  input  logic       loadN,
  input  logic       countEn,
  input  logic       carryEnIn,
  output cntStrobe_t strobe
);
  // Load outranks counting and ignores both enables
  always_comb begin
    strobe.load = !loadN;
    strobe.incr = loadN && countEn && carryEnIn;
  end
endmodule

// File: rtl/cnt_slice_dp.sv
module cnt_slice_dp
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clrN,
  input  cntStrobe_t   strobe,
  input  logic         carryEnIn,
  input  logic [W-1:0] presetVal,
  output logic [W-1:0] countQ,
  output logic         carryOut
);
  localparam logic [W-1:0] TERM_VAL = '1;
  localparam logic [W-1:0] STEP     = W'(1);

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)            countQ <= '0;
    else if (strobe.load) countQ <= presetVal;
    else if (strobe.incr) countQ <= countQ + STEP;
  end

  assign carryOut = carryEnIn && (countQ == TERM_VAL);
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clrN,
  input  logic         loadN,
  input  logic         countEn,
  input  logic         carryEnIn,
  input  logic [W-1:0] presetVal,
  output logic [W-1:0] countQ,
  output logic         carryOut
);
  cntStrobe_t strobe;

  cnt_slice_ctrl u_ctrl (
    .loadN    (loadN),
    .countEn  (countEn),
    .carryEnIn(carryEnIn),
    .strobe   (strobe)
  );

  cnt_slice_dp #(.W(W)) u_dp (
    .clk      (clk),
    .clrN     (clrN),
    .strobe   (strobe),
    .carryEnIn(carryEnIn),
    .presetVal(presetVal),
    .countQ   (countQ),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int NUM_SLICES = 2,
  parameter int SLICE_W    = 4
) (
  input  logic                          clk,
  input  logic                          clrN,
  input  logic                          loadN,
  input  logic                          countEn,
  input  logic                          carryEn,
  input  logic [NUM_SLICES*SLICE_W-1:0] presetVal,
  output logic [NUM_SLICES*SLICE_W-1:0] countOut,
  output logic                          carryOut
);
  localparam int TOTAL_W = NUM_SLICES * SLICE_W;

  // chainCarry[k] is the carry-enable of slice k
  logic [NUM_SLICES:0] chainCarry;
  logic [TOTAL_W-1:0]  countAll;

  assign chainCarry[0] = carryEn;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cnt_slice #(.W(SLICE_W)) u_slice (
      .clk      (clk),
      .clrN     (clrN),
      .loadN    (loadN),
      .countEn  (countEn),
      .carryEnIn(chainCarry[k]),
      .presetVal(presetVal[k*SLICE_W +: SLICE_W]),
      .countQ   (countAll[k*SLICE_W +: SLICE_W]),
      .carryOut (chainCarry[k+1])
    );
  end

  assign countOut = countAll;
  assign carryOut = chainCarry[NUM_SLICES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int TOTAL_W = 8
) (
  input logic               clk,
  input logic               clrN,
  input logic               loadN,
  input logic               countEn,
  input logic               carryEn,
  input logic [TOTAL_W-1:0] presetVal,
  input logic [TOTAL_W-1:0] countOut,
  input logic               carryOut
);
  // R1
  clear_zero_chk: assert property (@(negedge clk)
    !clrN |-> (countOut == '0 && !carryOut));

  // R2 R3 R11
  load_take_chk: assert property (@(posedge clk) disable iff (!clrN)
    !loadN |=> countOut == $past(presetVal));

  // R4 R9 R10
  step_one_chk: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && countEn && carryEn) |=> countOut == $past(countOut) + TOTAL_W'(1));

  // R5 R6
  hold_chk: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && !(countEn && carryEn)) |=> $stable(countOut));

  // R7
  carry_term_chk: assert property (@(negedge clk) disable iff (!clrN)
    carryOut |-> (carryEn && (&countOut)));

  // R8
  carry_gate_chk: assert property (@(negedge clk) disable iff (!clrN)
    !carryEn |-> !carryOut);
endmodule

bind cnt_chain cnt_chain_chk #(.TOTAL_W(NUM_SLICES*SLICE_W)) u_chk (
  .clk      (clk),
  .clrN     (clrN),
  .loadN    (loadN),
  .countEn  (countEn),
  .carryEn  (carryEn),
  .presetVal(presetVal),
  .countOut (countOut),
  .carryOut (carryOut)
);

// File: tb/cnt_chain_bench.sv
module cnt_chain_bench;
  localparam int NS = 2;
  localparam int SW = 4;
  localparam int TW = NS * SW;
  localparam logic [TW-1:0] ALL_ONES = '1;

  typedef struct {
    logic [TW-1:0] cnt;
    logic          cy;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          clrN = 1'b0;
  logic          loadN = 1'b1;
  logic          countEn = 1'b0;
  logic          carryEn = 1'b0;
  logic [TW-1:0] presetVal = '0;
  logic [TW-1:0] countOut;
  logic          carryOut;

  int checks = 0;
  int fails  = 0;
  logic [TW-1:0] model = '0;
  item_t expQ[$];
  item_t mItem;

  cnt_chain #(.NUM_SLICES(NS), .SLICE_W(SW)) u_cnt_chain (
    .clk(clk), .clrN(clrN), .loadN(loadN), .countEn(countEn),
    .carryEn(carryEn), .presetVal(presetVal),
    .countOut(countOut), .carryOut(carryOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [TW-1:0] gotCnt,
                       input logic gotCy, input logic [TW-1:0] expCnt,
                       input logic expCy);
    checks++;
    if (gotCnt !== expCnt || gotCy !== expCy) begin
      fails++;
      $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
               tag, gotCnt, gotCy, expCnt, expCy);
    end
  endtask

  // Driver: apply one cycle of inputs and push the expected result
  task automatic drive(input logic ld, input logic ce, input logic te,
                       input logic [TW-1:0] pv, input string tag);
    item_t it;
    @(negedge clk);
    loadN = ld; countEn = ce; carryEn = te; presetVal = pv;
    if (!ld)           model = pv;
    else if (ce && te) model = model + 1'b1;
    it.cnt = model;
    it.cy  = te && (model == ALL_ONES);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      mItem = expQ.pop_front();
      check(mItem.tag, countOut, carryOut, mItem.cnt, mItem.cy);
    end
  end

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: count=%h carry=%b expected count=%h carry=%b",
             countOut, carryOut, model, 1'b0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    carryEn = 1'b1;
    #1 check("R1 reset", countOut, carryOut, '0, 1'b0);
    @(negedge clk) clrN = 1'b1;
    model = '0;

    drive(1'b0, 1'b0, 1'b0, 8'hA5, "R3 load with enables low");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R4 increment");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R4 increment");
    drive(1'b1, 1'b0, 1'b1, 8'h00, "R5 hold countEn low");
    drive(1'b1, 1'b1, 1'b0, 8'h00, "R6 hold carryEn low");
    drive(1'b0, 1'b1, 1'b1, 8'h3C, "R2 load beats count");
    drive(1'b0, 1'b1, 1'b1, 8'h01, "R11 lsb");
    drive(1'b0, 1'b1, 1'b1, 8'h80, "R11 msb");
    drive(1'b0, 1'b0, 1'b1, 8'h0E, "R2 load");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R4 to 0F");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R10 slice carry 0F to 10");
    drive(1'b0, 1'b1, 1'b1, 8'hFD, "R2 load FD");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R4 to FE");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R7 carry at FF");
    drive(1'b1, 1'b0, 1'b1, 8'h00, "R7 carry held at FF");
    drive(1'b1, 1'b1, 1'b0, 8'h00, "R8 carry gated at FF");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R9 wrap to 00");

    // R9 R10: a full lap through every value
    for (int i = 0; i < 260; i++) drive(1'b1, 1'b1, 1'b1, 8'h00, "R10 lap");

    // R1: clear partway through a cycle, from FF with carry high
    drive(1'b0, 1'b0, 1'b1, 8'hFF, "R7 load FF");
    @(negedge clk);
    #3 clrN = 1'b0;
    #1 check("R1 async clear", countOut, carryOut, '0, 1'b0);

    // R1: clear wins over a load edge
    loadN = 1'b0; presetVal = 8'h55;
    @(posedge clk);
    #5 check("R1 clear over load", countOut, carryOut, '0, 1'b0);
    @(negedge clk);
    clrN = 1'b1; loadN = 1'b1;
    model = '0;
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R4 count after clear");
    drive(1'b1, 1'b1, 1'b1, 8'h00, "R4 count after clear");
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule